// File: doc/BRIEF.md
# Shared Memory Grant Generator

This block drives ingress flow control for a shared-memory packet switch whose input ports form two groups. Each group of ports writes into two sub-switch memories. The block receives four occupancy counts, one per sub-switch memory, and compares each count against a single programmable limit on every clock. A group's grant is on only while both of its memories sit strictly under the limit. There is no hysteresis, so the grant drops as soon as either count reaches the limit.

The grant bits go to the header-insertion logic and must stay constant for a whole packet cycle, so that every attached device sees the same flow-control state. For this reason the comparison results are latched into a small grant table only on a packet-cycle strobe.

When an occupancy count reaches the limit, a sticky status bit is set for that memory. Each status bit raises the interrupt line unless its mask bit is set. Software sets the limit, the mask and the write-one-to-clear status through a small register port. When it programs the limit, software should subtract the store addresses held back by the input controllers: 32 in the full-rate configuration and 16 in the half-rate one.

Top module: `memgrant_gen`

## Requirements
- R1: `grant[0]` follows sub-switch memories 0 and 1 (port group 0). `grant[1]` follows memories 2 and 3 (port group 1). Memory k's count is `occ_cnt[10k+9:10k]`.
- R2: At a strobe, a group's grant is latched as 1 only if both of its memories' counts are strictly less than the limit in force in that cycle.
- R3: At a strobe, a group's grant is latched as 0 if either of its counts is equal to or greater than the limit. Equality counts as reaching the limit, and no hysteresis applies.
- R4: `grant` updates on the clock edge where `pkt_strobe` is 1 and holds its value on every other edge.
- R5: After reset, `grant` is 0, all status bits are 0, all mask bits are 0, `irq` is 0 and the limit equals parameter `RST_THR` (992 by default).
- R6: On any edge where memory k's count is at or above the limit, status bit k is set. Once set, it stays set until software clears it.
- R7: A write to address 1 clears each status bit whose `reg_wdata` bit is 1. If the same memory is at or above the limit in that cycle, the set wins and the bit stays 1.
- R8: `irq` is 1 exactly when some status bit is 1 and its mask bit is 0.
- R9: A write to address 0 loads the limit from `reg_wdata[9:0]`. The new value first applies to the comparison on the following edge. Reading address 0 returns the limit.
- R10: A write to address 2 loads mask bits 3:0 from `reg_wdata[3:0]`. Reading address 2 returns the mask, reading address 1 returns the status bits, and reading address 3 returns 0. Reads are combinational on `reg_addr` when `reg_wr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_strobe | input | 1 | Packet-cycle boundary; latch the grant table |
| occ_cnt | input | 40 | Four 10-bit occupancy counts, memory 0 in the low bits |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 2 | Register select: 0 limit, 1 status, 2 mask |
| reg_wdata | input | 10 | Register write data |
| reg_rdata | output | 10 | Register read data for `reg_addr` |
| grant | output | 2 | Grant table, one bit per port group |
| irq | output | 1 | Interrupt, OR of unmasked status bits |

## Verification
The status register can receive a hardware set and a software clear for the same bit on the same edge. The bench provokes this directly by writing a clear while a memory stays above the limit, and it expects the bit to read back as 1. The random phase also hits the case often, because it holds the counts within a few steps of the limit while issuing random clears. A second coincidence occurs when a limit write lands on a strobe edge. In that case the bench model latches the grant from the old limit, and the rule takes effect only on the next edge.

// File: rtl/memgrant_pkg.sv
package memgrant_pkg;
   localparam int SEL_W = 2;
   typedef enum logic [SEL_W-1:0] {
      SEL_LIMIT  = 2'd0,
      SEL_STATUS = 2'd1,
      SEL_MASK   = 2'd2,
      SEL_NONE   = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/memgrant_cmp.sv
module memgrant_cmp #(
   parameter int CNT_W = 10,
   parameter int N_MEM = 4
) (
   input  logic [N_MEM*CNT_W-1:0] occ_flat,
   input  logic [CNT_W-1:0]       limit,
   output logic [N_MEM-1:0]       at_limit
);
   for (genvar k = 0; k < N_MEM; k++) begin : g_cmp
      assign at_limit[k] = occ_flat[k*CNT_W +: CNT_W] >= limit;
   end
endmodule

// File: rtl/memgrant_table.sv
module memgrant_table #(
   parameter int N_GRP   = 2,
   parameter int MEM_PER = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     pkt_strobe,
   input  logic [N_GRP*MEM_PER-1:0] at_limit,
   output logic [N_GRP-1:0]         grant
);
   logic [N_GRP-1:0] grant_nxt;
   logic [N_GRP-1:0] grant_q;

   for (genvar g = 0; g < N_GRP; g++) begin : g_grp
      assign grant_nxt[g] = ~|at_limit[g*MEM_PER +: MEM_PER];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          grant_q <= '0;
      else if (pkt_strobe) grant_q <= grant_nxt;
   end

   assign grant = grant_q;

   // R4: table holds between packet-cycle strobes
   p_grant_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !pkt_strobe |=> $stable(grant));
endmodule

// File: rtl/memgrant_regs.sv
module memgrant_regs
   import memgrant_pkg::*;
#(
   parameter int CNT_W   = 10,
   parameter int N_MEM   = 4,
   parameter int RST_THR = 992
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic [SEL_W-1:0]   reg_addr,
   input  logic [CNT_W-1:0]   reg_wdata,
   input  logic [N_MEM-1:0]   at_limit,
   output logic [CNT_W-1:0]   limit,
   output logic [CNT_W-1:0]   reg_rdata,
   output logic               irq
);
   localparam logic [CNT_W-1:0] LIMIT_INIT = CNT_W'(RST_THR);

   reg_sel_e         sel;
   logic [CNT_W-1:0] limit_q;
   logic [N_MEM-1:0] mask_q;
   logic [N_MEM-1:0] stat_q;
   logic [N_MEM-1:0] clr_vec;

   assign sel     = reg_sel_e'(reg_addr);
   assign clr_vec = (reg_wr && sel == SEL_STATUS) ? reg_wdata[N_MEM-1:0] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         limit_q <= LIMIT_INIT;
         mask_q  <= '0;
      end else if (reg_wr) begin
         if (sel == SEL_LIMIT) limit_q <= reg_wdata;
         if (sel == SEL_MASK)  mask_q  <= reg_wdata[N_MEM-1:0];
      end
   end

   // set beats clear in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (stat_q & ~clr_vec) | at_limit;
   end

   always_comb begin
      unique case (sel)
         SEL_LIMIT:  reg_rdata = limit_q;
         SEL_STATUS: reg_rdata = CNT_W'(stat_q);
         SEL_MASK:   reg_rdata = CNT_W'(mask_q);
         default:    reg_rdata = '0;
      endcase
   end

   assign limit = limit_q;
   assign irq   = |(stat_q & ~mask_q);

   // R8: interrupt only with a pending status bit
   p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (stat_q != '0));

   for (genvar k = 0; k < N_MEM; k++) begin : g_chk
      // R6: reaching the limit marks the status bit
      p_stat_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
         at_limit[k] |=> stat_q[k]);
      // R6: sticky without a clear
      p_stat_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (stat_q[k] && !clr_vec[k]) |=> stat_q[k]);
      // R7: clear works when no new set arrives
      p_stat_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_vec[k] && !at_limit[k]) |=> !stat_q[k]);
   end
endmodule

// File: rtl/memgrant_gen.sv
module memgrant_gen
   import memgrant_pkg::*;
#(
   parameter int CNT_W   = 10,
   parameter int N_GRP   = 2,
   parameter int MEM_PER = 2,
   parameter int RST_THR = 992,
   localparam int N_MEM  = N_GRP * MEM_PER
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    pkt_strobe,
   input  logic [N_MEM*CNT_W-1:0]  occ_cnt,
   input  logic                    reg_wr,
   input  logic [SEL_W-1:0]        reg_addr,
   input  logic [CNT_W-1:0]        reg_wdata,
   output logic [CNT_W-1:0]        reg_rdata,
   output logic [N_GRP-1:0]        grant,
   output logic                    irq
);
   if (N_MEM > CNT_W) begin : g_bad_width
      $error("memgrant_gen: status bits must fit in the data width");
   end
   if (RST_THR < 0 || RST_THR >= (1 << CNT_W)) begin : g_bad_thr
      $error("memgrant_gen: RST_THR out of range");
   end
   if (MEM_PER < 1 || N_GRP < 1) begin : g_bad_grp
      $error("memgrant_gen: empty grouping");
   end

   logic [CNT_W-1:0] limit;
   logic [N_MEM-1:0] at_limit;

   memgrant_cmp #(.CNT_W(CNT_W), .N_MEM(N_MEM)) u_cmp (
      .occ_flat (occ_cnt),
      .limit    (limit),
      .at_limit (at_limit)
   );

   memgrant_table #(.N_GRP(N_GRP), .MEM_PER(MEM_PER)) u_table (
      .clk        (clk),
      .rst_n      (rst_n),
      .pkt_strobe (pkt_strobe),
      .at_limit   (at_limit),
      .grant      (grant)
   );

   memgrant_regs #(.CNT_W(CNT_W), .N_MEM(N_MEM), .RST_THR(RST_THR)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .at_limit  (at_limit),
      .limit     (limit),
      .reg_rdata (reg_rdata),
      .irq       (irq)
   );

   for (genvar g = 0; g < N_GRP; g++) begin : g_grant_chk
      // R3: a full memory at a strobe withdraws its group's grant
      p_grant_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (pkt_strobe && |at_limit[g*MEM_PER +: MEM_PER]) |=> !grant[g]);
      // R2: all memories under the limit at a strobe grant the group
      p_grant_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (pkt_strobe && !(|at_limit[g*MEM_PER +: MEM_PER])) |=> grant[g]);
   end
endmodule

// File: tb/memgrant_gen_tb.sv
module memgrant_gen_tb;
   localparam int CW  = 10;
   localparam int RST = 992;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          strobe = 1'b0;
   logic [CW-1:0] occ_v [4];
   logic [4*CW-1:0] occ_flat;
   logic          wr = 1'b0;
   logic [1:0]    addr = 2'd0;
   logic [CW-1:0] wdata = '0;
   logic [CW-1:0] rdata;
   logic [1:0]    grant;
   logic          irq;

   int checks = 0;
   int errors = 0;
   logic [1:0]    m_grant;
   logic [3:0]    m_stat, m_mask;
   logic [CW-1:0] m_thr;

   assign occ_flat = {occ_v[3], occ_v[2], occ_v[1], occ_v[0]};

   always #5 clk = ~clk;

   memgrant_gen #(.RST_THR(RST)) u_dut (
      .clk(clk), .rst_n(rst_n), .pkt_strobe(strobe), .occ_cnt(occ_flat),
      .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
      .grant(grant), .irq(irq)
   );

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [CW-1:0] exp_read(logic [1:0] a);
      case (a)
         2'd0: return m_thr;
         2'd1: return CW'(m_stat);
         2'd2: return CW'(m_mask);
         default: return '0;
      endcase
   endfunction

   task automatic tick();
      logic [3:0] ov;
      logic [3:0] clr;
      @(posedge clk);
      for (int k = 0; k < 4; k++) ov[k] = occ_v[k] >= m_thr;
      if (strobe) m_grant = {~(ov[3] | ov[2]), ~(ov[1] | ov[0])};
      clr = (wr && addr == 2'd1) ? wdata[3:0] : 4'd0;
      m_stat = (m_stat & ~clr) | ov;
      if (wr && addr == 2'd0) m_thr = wdata;
      if (wr && addr == 2'd2) m_mask = wdata[3:0];
      @(negedge clk);
      check("R2/R3/R4 grant table", 16'(grant), 16'(m_grant));
      check("R8 irq", 16'(irq), 16'(|(m_stat & ~m_mask)));
      if (!wr) check("R10 readback", 16'(rdata), 16'(exp_read(addr)));
   endtask

   task automatic wreg(logic [1:0] a, logic [CW-1:0] d);
      wr = 1'b1; addr = a; wdata = d;
      tick();
      wr = 1'b0;
   endtask

   task automatic rreg(logic [1:0] a, string req, logic [CW-1:0] exp);
      addr = a;
      #1;
      check(req, 16'(rdata), 16'(exp));
   endtask

   initial begin : watchdog
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20417));
      for (int k = 0; k < 4; k++) occ_v[k] = '0;
      m_grant = '0; m_stat = '0; m_mask = '0; m_thr = CW'(RST);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R5 reset state
      check("R5 grant after reset", 16'(grant), 16'd0);
      check("R5 irq after reset", 16'(irq), 16'd0);
      rreg(2'd0, "R5 limit after reset", CW'(RST));
      rreg(2'd1, "R5 status after reset", '0);
      rreg(2'd2, "R5 mask after reset", '0);

      // R9 program limit
      wreg(2'd0, 10'd100);
      rreg(2'd0, "R9 limit readback", 10'd100);

      // R3 equality on memory 0 only withdraws group 0 (R1)
      occ_v[0] = 10'd100; strobe = 1'b1; tick(); strobe = 1'b0;
      check("R3 R1 equality drops group 0 only", 16'(grant), 16'b10);
      rreg(2'd1, "R6 status bit 0 set", 10'b0001);
      check("R8 irq on unmasked status", 16'(irq), 16'd1);

      // R2 one below limit grants
      occ_v[0] = 10'd99; strobe = 1'b1; tick(); strobe = 1'b0;
      check("R2 both below grants", 16'(grant), 16'b11);
      rreg(2'd1, "R6 status sticky", 10'b0001);

      // R4 no strobe keeps the table
      occ_v[2] = 10'd200;
      repeat (3) tick();
      check("R4 held without strobe", 16'(grant), 16'b11);
      strobe = 1'b1; tick(); strobe = 1'b0;
      check("R1 group 1 follows memory 2", 16'(grant), 16'b01);

      // R7 set wins over clear in the same cycle
      wreg(2'd1, 10'b0100);
      rreg(2'd1, "R7 set beats clear", 10'b0101);
      occ_v[2] = 10'd0;
      wreg(2'd1, 10'b0101);
      rreg(2'd1, "R7 clear when below", 10'b0000);
      check("R8 irq idle after clear", 16'(irq), 16'd0);

      // R8 masking
      occ_v[3] = 10'd500; tick(); occ_v[3] = 10'd0;
      check("R8 irq from memory 3", 16'(irq), 16'd1);
      wreg(2'd2, 10'b1000);
      check("R8 masked status hides irq", 16'(irq), 16'd0);
      rreg(2'd2, "R10 mask readback", 10'b1000);
      rreg(2'd3, "R10 unused address", 10'd0);
      wreg(2'd1, 10'b1111);
      wreg(2'd2, 10'b0000);

      // random phase with counts hugging the limit
      for (int n = 0; n < 4000; n++) begin
         for (int k = 0; k < 4; k++) begin
            int v;
            v = int'(m_thr) + int'($urandom_range(0, 8)) - 4;
            if (v < 0) v = 0;
            if (v > 1023) v = 1023;
            occ_v[k] = CW'(v);
         end
         strobe = ($urandom_range(0, 3) == 0);
         wr     = ($urandom_range(0, 5) == 0);
         addr   = 2'($urandom_range(0, 3));
         if (wr && addr == 2'd0) wdata = CW'($urandom_range(4, 1019));
         else                    wdata = CW'($urandom_range(0, 15));
         tick();
      end
      wr = 1'b0; strobe = 1'b0;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule